// File: doc/BRIEF.md
# Key-Guarded Watchdog Counter

An 8-bit watchdog counter with three byte-wide registers: a control/status register, the counter itself and a reset control/status register. After software sets the run bit, the counter advances on single-cycle ticks from a free-running prescaler. A 3-bit select field picks one of eight prescaler taps. When the counter wraps from 0xFF to 0x00, an overflow flag is latched. If reset generation is armed, the wrap also sends a one-cycle reset request to the system reset logic and records that a reset was requested.

Writes arrive only as 16-bit words at even addresses. The upper byte is a key that says which register the low byte goes to. A word whose key does not match its address is dropped. Reads use byte addresses, and they differ from the write addresses: the counter is read at address 1 and the reset register at address 3. Both sticky flags follow a read-then-clear rule. Software must first observe a flag as 1 and then write 0 to it. Writing 1 to a flag never changes it.

Top module: `pwd_watchdog`

## Requirements
- R1: After reset, read address 0 returns 0x18, read address 1 returns 0x00, read address 3 returns 0x3F, and `rst_req` is 0. The control register layout is: bit 7 overflow flag, bit 6 reads 0, bit 5 run, bits 4:3 read 1, bits 2:0 tap select. The reset register layout is: bit 7 reset-requested flag, bit 6 reset arm, bits 5:0 read 1.
- R2: A write at address 0 with key 0xA5 loads the control register from the low byte. A write at address 0 with key 0x5A loads the counter. A write at address 2 with key 0xA5 loads the reset register. Any other key, and any odd write address, leaves every register unchanged.
- R3: While run is 1, the counter increments by one on each prescaler tick. A counter write in the same cycle takes precedence over the increment.
- R4: When run is 0, the counter is 0x00 from the cycle in which run is written 0. Counter writes have no effect while run is 0.
- R5: The prescaler runs freely from reset. Select values 0 to 7 give a tick every 2, 8, 32, 64, 256, 512, 2048 and 4096 cycles.
- R6: A tick that takes the counter from 0xFF to 0x00 sets the overflow flag.
- R7: Writing 1 to the overflow flag has no effect. Writing 0 clears the flag only if the flag was read as 1 at address 0, with `rd_en` high, since the last clear.
- R8: A qualifying clear written in the same cycle as a new wrap is lost, so the flag stays 1. A later zero write then clears it without another read.
- R9: With reset arm set, a wrap raises `rst_req` for exactly one cycle and sets the reset-requested flag. With reset arm clear, a wrap raises no request.
- R10: The reset-requested flag clears only when 0 is written to it after it has been read as 1 at address 3. Writing 1 to it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it also drives the prescaler |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Word write strobe |
| wr_addr | input | 2 | Write byte address (0 or 2) |
| wr_data | input | 16 | Key in bits 15:8, data in bits 7:0 |
| rd_en | input | 1 | Read strobe; it marks a flag as seen |
| rd_addr | input | 2 | Read byte address |
| rd_data | output | 8 | Combinational read data |
| rst_req | output | 1 | One-cycle reset request on an armed wrap |

## Verification
A zero write that clears the overflow flag can land on the same clock edge as a counter wrap. With the fastest tap selected, the bench loads 0xFE and polls the counter until it reads 0xFF, which shows that a tick has just occurred. It then places the clear write two edges later, on the next tick. It judges the result by reading the flag back as still set, and then checks that a plain zero write clears it afterwards.

// File: rtl/pwd_watchdog.sv
module pwd_watchdog #(
  parameter int         DIV_W   = 12,
  parameter logic [7:0] KEY_CTL = 8'hA5,
  parameter logic [7:0] KEY_CNT = 8'h5A,
  parameter logic [7:0] KEY_RST = 8'hA5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [15:0] wr_data,
  input  logic        rd_en,
  input  logic [1:0]  rd_addr,
  output logic [7:0]  rd_data,
  output logic        rst_req
);

  localparam logic [7:0] CNT_TOP = 8'hFF;

  function automatic int tap_bit(input logic [2:0] s);
    case (s)
      3'd0: return 0;
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 5;
      3'd4: return 7;
      3'd5: return 8;
      3'd6: return 10;
      default: return 11;
    endcase
  endfunction

  logic [DIV_W-1:0] div_q;
  logic [7:0]       cnt_q;
  logic [2:0]       sel_q;
  logic             run_q, ovf_q, ovf_seen_q;
  logic             rflag_q, rflag_seen_q, arm_q, rst_req_q;
  logic [DIV_W-1:0] tap_mask;

  wire [7:0] key    = wr_data[15:8];
  wire wr_ctl       = wr_en && wr_addr == 2'd0 && key == KEY_CTL;
  wire wr_cnt       = wr_en && wr_addr == 2'd0 && key == KEY_CNT;
  wire wr_rst       = wr_en && wr_addr == 2'd2 && key == KEY_RST;
  wire unused_bits  = ^wr_data[4:3];

  always_comb tap_mask = DIV_W'((1 << (tap_bit(sel_q) + 1)) - 1);

  wire tick    = (div_q & tap_mask) == tap_mask;
  wire run_nxt = wr_ctl ? wr_data[5] : run_q;
  wire wrap    = run_q && run_nxt && tick && !wr_cnt && cnt_q == CNT_TOP;
  wire ovf_clr = wr_ctl && !wr_data[7] && ovf_seen_q;
  wire rfl_clr = wr_rst && !wr_data[7] && rflag_seen_q;
  wire hit     = wrap && arm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q        <= '0;
      cnt_q        <= '0;
      sel_q        <= '0;
      run_q        <= 1'b0;
      ovf_q        <= 1'b0;
      ovf_seen_q   <= 1'b0;
      rflag_q      <= 1'b0;
      rflag_seen_q <= 1'b0;
      arm_q        <= 1'b0;
      rst_req_q    <= 1'b0;
    end else begin
      div_q <= div_q + 1'b1;
      run_q <= run_nxt;
      if (wr_ctl) sel_q <= wr_data[2:0];
      if (wr_rst) arm_q <= wr_data[6];

      if (!run_nxt)              cnt_q <= '0;
      else if (wr_cnt)           cnt_q <= wr_data[7:0];
      else if (run_q && tick)    cnt_q <= cnt_q + 1'b1;

      ovf_q <= wrap | (ovf_q & ~ovf_clr);
      if (ovf_clr && !wrap)                        ovf_seen_q <= 1'b0;
      else if (rd_en && rd_addr == 2'd0 && ovf_q)  ovf_seen_q <= 1'b1;

      rflag_q <= hit | (rflag_q & ~rfl_clr);
      if (rfl_clr && !hit)                           rflag_seen_q <= 1'b0;
      else if (rd_en && rd_addr == 2'd3 && rflag_q)  rflag_seen_q <= 1'b1;

      rst_req_q <= hit;
    end
  end

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = {ovf_q, 1'b0, run_q, 2'b11, sel_q};
      2'd1:    rd_data = cnt_q;
      2'd3:    rd_data = {rflag_q, arm_q, 6'h3F};
      default: rd_data = 8'hFF;
    endcase
  end

  assign rst_req = rst_req_q;

endmodule

module pwd_watchdog_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] cnt_q,
  input logic       run_q,
  input logic       ovf_q,
  input logic       rflag_q,
  input logic       rst_req
);

  // R6
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run_q) && run_q && !$past(wr_en) && $past(cnt_q) == 8'hFF && cnt_q == 8'h00) |-> ovf_q);

  // R7
  flag_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> $past(cnt_q) == 8'hFF);

  // R4
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> cnt_q == 8'h00);

  // R3
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q) && !$past(wr_en)) |-> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 8'd1));

  // R9
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R9
  pulse_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> rflag_q);

endmodule

bind pwd_watchdog pwd_watchdog_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cnt_q(cnt_q),
  .run_q(run_q), .ovf_q(ovf_q), .rflag_q(rflag_q), .rst_req(rst_req)
);

// File: tb/test_pwd_watchdog.sv
module test_pwd_watchdog;
  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0, rd_addr = 2'd0;
  logic [15:0] wr_data = 16'h0;
  wire  [7:0]  rd_data;
  wire         rst_req;

  pwd_watchdog i_pwd_watchdog (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rst_req(rst_req)
  );

  always #4 clk = ~clk;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  int sb_err = 0, sb_chk = 0, dir_err = 0, dir_chk = 0, pulses = 0;

  always @(negedge clk) if (rst_n && rst_req) pulses++;

  always @(negedge clk) begin
    logic [7:0] e;
    string t;
    #1;
    if (rd_en && exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      sb_chk++;
      if (rd_data !== e) begin
        sb_err++;
        $display("FAIL %s: rd_data=%h expected %h", t, rd_data, e);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] k, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = {k, d};
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic peek(output logic [7:0] v);
    @(negedge clk); rd_addr = 2'd1; #1 v = rd_data;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    dir_chk++;
    if (act != exp) begin
      dir_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic window(input int m, input int per, input string tag);
    logic [7:0] base;
    peek(base);
    repeat (m - 1) @(negedge clk);
    rd(2'd1, base + 8'(m / per), tag);
  endtask

  task automatic make_wrap(input bit do_read);
    wr(2'd0, 8'h5A, 8'hFE);
    repeat (5) @(negedge clk);
    if (do_read) rd(2'd0, 8'hB8, "R6 flag after wrap");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog: run hung, actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", sb_err + dir_err + 1, sb_chk + dir_chk + 1);
    $finish;
  end

  initial begin
    int p0;
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 rst_req idle", int'(rst_req), 0);
    rd(2'd0, 8'h18, "R1 control reset");
    rd(2'd1, 8'h00, "R1 counter reset");
    rd(2'd3, 8'h3F, "R1 reset reg reset");

    wr(2'd0, 8'h33, 8'h20);
    rd(2'd0, 8'h18, "R2 bad key ignored");
    wr(2'd1, 8'hA5, 8'h20);
    rd(2'd0, 8'h18, "R2 odd address ignored");

    wr(2'd0, 8'hA5, 8'h20);
    window(40, 2, "R3 R5 div2 count");
    wr(2'd0, 8'hA5, 8'h21);
    window(80, 8, "R5 div8 count");
    wr(2'd0, 8'hA5, 8'h27);
    rd(2'd0, 8'h3F, "R2 control loaded");
    window(8192, 4096, "R5 div4096 count");

    wr(2'd0, 8'hA5, 8'h00);
    rd(2'd1, 8'h00, "R4 stop clears counter");
    repeat (50) @(negedge clk);
    rd(2'd1, 8'h00, "R4 stays zero");
    wr(2'd0, 8'h5A, 8'h44);
    rd(2'd1, 8'h00, "R4 write while stopped");

    wr(2'd0, 8'hA5, 8'h20);
    wr(2'd0, 8'h5A, 8'hFE);
    repeat (5) @(negedge clk);
    rd(2'd1, 8'h01, "R6 counter wrapped");
    rd(2'd0, 8'hB8, "R6 flag set");
    wr(2'd0, 8'hA5, 8'h20);
    rd(2'd0, 8'h38, "R7 clear after read");

    make_wrap(1'b0);
    wr(2'd0, 8'hA5, 8'h20);
    rd(2'd0, 8'hB8, "R7 clear without read ignored");
    wr(2'd0, 8'hA5, 8'hA0);
    rd(2'd0, 8'hB8, "R7 writing one keeps flag");
    wr(2'd0, 8'hA5, 8'h20);
    rd(2'd0, 8'h38, "R7 clear after seen");
    wr(2'd0, 8'hA5, 8'hA0);
    rd(2'd0, 8'h38, "R7 writing one cannot set");

    make_wrap(1'b1);
    wr(2'd0, 8'h5A, 8'hFE);
    do begin @(negedge clk); rd_addr = 2'd1; #1; end while (rd_data != 8'hFF);
    wr(2'd0, 8'hA5, 8'h20);
    rd(2'd0, 8'hB8, "R8 clear lost on wrap");
    wr(2'd0, 8'hA5, 8'h20);
    rd(2'd0, 8'h38, "R8 later clear works");

    wr(2'd2, 8'hA5, 8'h40);
    rd(2'd3, 8'h7F, "R9 arm loaded");
    p0 = pulses;
    wr(2'd0, 8'h5A, 8'hFE);
    repeat (10) @(negedge clk);
    chk("R9 one request cycle", pulses - p0, 1);
    wr(2'd2, 8'hA5, 8'h40);
    rd(2'd3, 8'hFF, "R10 clear without read ignored");
    wr(2'd2, 8'hA5, 8'hC0);
    rd(2'd3, 8'hFF, "R10 writing one keeps flag");
    wr(2'd2, 8'hA5, 8'h40);
    rd(2'd3, 8'h7F, "R10 clear after read");

    wr(2'd2, 8'hA5, 8'h00);
    wr(2'd2, 8'h5A, 8'h40);
    rd(2'd3, 8'h3F, "R2 reset reg bad key");
    p0 = pulses;
    wr(2'd0, 8'h5A, 8'hFE);
    repeat (10) @(negedge clk);
    chk("R9 unarmed no request", pulses - p0, 0);
    rd(2'd3, 8'h3F, "R9 unarmed flag clear");

    wait (exp_q.size() == 0);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", sb_err + dir_err, sb_chk + dir_chk);
    $finish;
  end
endmodule